// File: doc/BRIEF.md
# Variable-Latency In-Order Stage Pipeline

This block is a timing model of a four-stage in-order pipeline. Each token that enters carries a tag and one small occupancy count per stage, and a stage stays busy with a token for exactly that many cycles. Between neighbouring stages sits a multi-entry first-in first-out queue. A stage can therefore drop a finished token into the queue and take its next token at once, even if the stage below has not yet taken the finished one. The block performs no data operation. It only works out when each token retires.

Tokens arrive on a valid/ready stream. Retirements leave as a one-cycle pulse that carries the tag and a timestamp from a free-running cycle counter. An architecture study can feed it instruction streams with per-stage costs and read back the completion cycles. A queue that fills up back-pressures the stage above it, and that pressure spreads up to the input handshake.

Top module: `stage_timing_pipe`

## Requirements
- R1: A token passes through stages 1 to 4 in order and occupies stage k for exactly its count for that stage. The count for stage k (k = 1..4) is `in_cnt[3k-1:3k-3]`, so stage 1 uses the lowest three bits. A token alone in the pipe with counts (3,5,2,7), accepted in cycle 0, retires stamped 17.
- R2: A count field of 0 behaves exactly like a count of 1. All-zero tokens accepted in cycles 0, 1 and 2 retire stamped 4, 5 and 6.
- R3: A token starts a stage in the cycle after the later of two events: its own release from the previous stage, and the release of this stage by the token ahead of it.
- R4: A stage takes its next token in the cycle after it hands a finished token to its output queue, even if the stage below is still busy. With tokens (1,6,1,1), (1,1,1,1), (1,1,1,1) offered back to back from cycle 0, the third token is accepted in cycle 2 and the second retires stamped 10.
- R5: Each inter-stage queue holds `QUEUE_DEPTH` (4) tokens. A stage whose output queue is full and not being read keeps its finished token and stays occupied. Ten tokens (1,7,1,1) offered back to back from cycle 0 accept the seventh token in cycle 8. With the pipe empty, `in_ready` is high.
- R6: A token accepted in cycle t (`in_valid` and `in_ready` both high) starts stage 1 in cycle t+1. `in_ready` is high when stage 1 is idle, or when it is in its final cycle and able to release its token.
- R7: Tokens never overtake. Retirement order equals acceptance order, and each retirement carries the tag the token entered with. No more than 4 + 3·`QUEUE_DEPTH` tokens are ever in flight.
- R8: `ret_valid` is high for exactly one cycle per accepted token, in that token's final stage-4 cycle, and never without a token in flight.
- R9: Synchronous reset empties every stage and queue. `ret_cycle` reads 0 in the first cycle after reset and rises by 1 every cycle, stamping each retirement with the value of its final stage-4 cycle.
- R10: The token sequence (2,1,1,1), (1,3,2,2), (2,1,1,3), (1,2,2,2), offered twice back to back from cycle 0, retires stamped 5, 10, 13, 15, 16, 18, 21, 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A token is offered |
| in_ready | output | 1 | Stage 1 can take the offered token this cycle |
| in_tag | input | 8 | Tag of the offered token |
| in_cnt | input | 12 | Four 3-bit per-stage occupancy counts, stage 1 in the low bits |
| ret_valid | output | 1 | A token finishes stage 4 in this cycle |
| ret_tag | output | 8 | Tag of the retiring token |
| ret_cycle | output | 16 | Free-running cycle counter; the retirement timestamp when `ret_valid` is high |

## Verification
The hardest situation to reach is a full inter-stage queue while the stage below it is still busy. At that point a finished token has to sit in its stage, and the back-pressure must reach `in_ready` on exactly the right cycle. The stimulus gets there with runs of tokens that are cheap upstream and expensive in one downstream stage. The bench also sweeps all 4096 count combinations, zeros included, as one stream with occasional gaps. A bench-side recurrence model predicts every acceptance cycle and every retirement stamp, including the cycles a queue-full stall adds.

// File: rtl/stp_pkg.sv
package stp_pkg;

    parameter int NUM_STAGES = 4;
    parameter int CNT_W      = 3;
    parameter int TAG_W      = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [TAG_W-1:0]        tag;
        cnt_t [NUM_STAGES-1:0]   cnt;
    } token_t;

    // A zero field is not a legal occupancy; it costs one cycle.
    function automatic cnt_t occupancy(input cnt_t raw);
        return (raw == '0) ? cnt_t'(1) : raw;
    endfunction

endpackage

// File: rtl/stp_cycle_ctr.sv
module stp_cycle_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + W'(1);
    end
endmodule

// File: rtl/stp_stage.sv
module stp_stage
    import stp_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,       // take load_tok at this edge
    input  token_t load_tok,
    input  logic   down_ok,    // finished token can leave at this edge
    output logic   can_take,
    output logic   at_end,     // final (or stalled) cycle of the held token
    output logic   release_now,
    output token_t held
);
    logic busy;
    cnt_t left;

    assign at_end      = busy && (left == cnt_t'(1));
    assign release_now = at_end && down_ok;
    assign can_take    = !busy || release_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
            held <= '0;
        end else if (load) begin
            busy <= 1'b1;
            left <= occupancy(load_tok.cnt[IDX]);
            held <= load_tok;
        end else if (release_now) begin
            busy <= 1'b0;
        end else if (busy && (left > cnt_t'(1))) begin
            left <= left - cnt_t'(1);
        end
    end
endmodule

// File: rtl/stp_queue.sv
module stp_queue
    import stp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   arrive,     // upstream stage holds a finished token
    input  token_t in_tok,
    input  logic   push,
    input  logic   pop,
    output logic   out_valid,
    output token_t out_tok,
    output logic   room
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILL_W = $clog2(DEPTH + 1);

    token_t             mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [FILL_W-1:0]  fill;
    logic               empty, store, drain;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty     = (fill == '0);
    assign out_valid = !empty || arrive;
    assign out_tok   = empty ? in_tok : mem[rd_ptr];
    assign room      = (fill < FILL_W'(DEPTH));
    // An empty queue passes a token straight through when it is read at once.
    assign store     = push && !(empty && pop);
    assign drain     = pop && !empty;

    always_ff @(posedge clk) begin
        if (store) mem[wr_ptr] <= in_tok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (store) wr_ptr <= step(wr_ptr);
            if (drain) rd_ptr <= step(rd_ptr);
            case ({store, drain})
                2'b10:   fill <= fill + FILL_W'(1);
                2'b01:   fill <= fill - FILL_W'(1);
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/stage_timing_pipe.sv
module stage_timing_pipe
    import stp_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4,
    parameter int CYC_W       = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [TAG_W-1:0]            in_tag,
    input  logic [NUM_STAGES*CNT_W-1:0] in_cnt,
    output logic                        ret_valid,
    output logic [TAG_W-1:0]            ret_tag,
    output logic [CYC_W-1:0]            ret_cycle
);
    localparam int LAST = NUM_STAGES - 1;

    token_t in_token;
    token_t feed_tok  [NUM_STAGES];
    token_t held_tok  [NUM_STAGES];
    logic   feed_vld  [NUM_STAGES];
    logic   take      [NUM_STAGES];
    logic   can_take  [NUM_STAGES];
    logic   at_end    [NUM_STAGES];
    logic   rel       [NUM_STAGES];
    logic   down_ok   [NUM_STAGES];
    logic   q_vld     [NUM_STAGES];
    logic   q_room    [NUM_STAGES];
    token_t q_tok     [NUM_STAGES];
    logic [CYC_W-1:0] cyc_now;

    assign in_token.tag = in_tag;
    assign in_token.cnt = in_cnt;

    stp_cycle_ctr #(.W(CYC_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .count (cyc_now)
    );

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_src_in
            assign feed_vld[g] = in_valid;
            assign feed_tok[g] = in_token;
        end else begin : g_src_q
            assign feed_vld[g] = q_vld[g-1];
            assign feed_tok[g] = q_tok[g-1];
        end

        assign take[g] = can_take[g] && feed_vld[g];

        stp_stage #(.IDX(g)) u_stage (
            .clk         (clk),
            .rst         (rst),
            .load        (take[g]),
            .load_tok    (feed_tok[g]),
            .down_ok     (down_ok[g]),
            .can_take    (can_take[g]),
            .at_end      (at_end[g]),
            .release_now (rel[g]),
            .held        (held_tok[g])
        );

        if (g < LAST) begin : g_queue
            stp_queue #(.DEPTH(QUEUE_DEPTH)) u_q (
                .clk       (clk),
                .rst       (rst),
                .arrive    (at_end[g]),
                .in_tok    (held_tok[g]),
                .push      (rel[g]),
                .pop       (take[g+1]),
                .out_valid (q_vld[g]),
                .out_tok   (q_tok[g]),
                .room      (q_room[g])
            );
            assign down_ok[g] = q_room[g] || take[g+1];
        end else begin : g_sink
            assign down_ok[g] = 1'b1;
            assign q_vld[g]   = 1'b0;
            assign q_room[g]  = 1'b0;
            assign q_tok[g]   = '0;
        end
    end

    assign in_ready  = can_take[0];
    assign ret_valid = rel[LAST];
    assign ret_tag   = held_tok[LAST].tag;
    assign ret_cycle = cyc_now;
endmodule

// File: rtl/stp_checker.sv
module stp_checker #(
    parameter int CYC_W        = 16,
    parameter int MAX_INFLIGHT = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             ret_valid,
    input logic [CYC_W-1:0] cycle
);
    logic [15:0] inflight;

    always_ff @(posedge clk) begin
        if (rst) inflight <= '0;
        else inflight <= inflight + 16'(in_valid && in_ready) - 16'(ret_valid);
    end

    a_r9_counter_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cycle == '0);

    a_r9_counter_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cycle == CYC_W'($past(cycle) + CYC_W'(1)));

    a_r7_capacity: assert property (@(posedge clk) disable iff (rst)
        inflight <= 16'(MAX_INFLIGHT));

    a_r8_no_phantom: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> inflight != '0);

    a_r6_min_latency: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> cycle >= CYC_W'(4));

    a_r5_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
        inflight == '0 |-> in_ready);
endmodule

bind stage_timing_pipe stp_checker #(
    .CYC_W        (CYC_W),
    .MAX_INFLIGHT (stp_pkg::NUM_STAGES + (stp_pkg::NUM_STAGES - 1) * QUEUE_DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .ret_valid (ret_valid),
    .cycle     (ret_cycle)
);

// File: tb/stage_timing_pipe_tb.sv
`timescale 1ns/1ps
module stage_timing_pipe_tb;
    import stp_pkg::*;

    localparam int QD   = 4;
    localparam int CW   = 16;
    localparam int MAXT = 4200;
    localparam int FW   = NUM_STAGES * CNT_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [TAG_W-1:0] in_tag = '0;
    logic [FW-1:0]    in_cnt = '0;
    logic ret_valid;
    logic [TAG_W-1:0] ret_tag;
    logic [CW-1:0]    ret_cycle;

    always #2 clk = ~clk;

    stage_timing_pipe #(.QUEUE_DEPTH(QD), .CYC_W(CW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_cnt(in_cnt), .ret_valid(ret_valid),
        .ret_tag(ret_tag), .ret_cycle(ret_cycle)
    );

    int n_cmp = 0, n_bad = 0, total = 0, cyc = 0;
    int n_tok = 0, n_ret = 0;
    string cur_req = "R9";
    int s_st [MAXT][4];
    int r_st [MAXT][4];
    int exp_ret [MAXT];
    int obs [MAXT];
    int acc [MAXT];

    always @(posedge clk) begin
        total <= total + 1;
        cyc   <= rst ? 0 : cyc + 1;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(posedge clk) begin
        if (total > 190000) begin
            n_bad++;
            $display("FAIL watchdog expired (%s) actual=%0d expected=%0d", cur_req, n_ret, n_tok);
            summary();
        end
    end

    // Retirement monitor (R7 order and tag, R8 one pulse per token)
    always @(negedge clk) begin
        if (!rst && ret_valid) begin
            if (n_ret < n_tok) begin
                chk(ret_tag == TAG_W'(n_ret), {cur_req, " R7 retire tag"}, int'(ret_tag), n_ret % 256);
                chk(int'(ret_cycle) == exp_ret[n_ret], {cur_req, " retire stamp"},
                    int'(ret_cycle), exp_ret[n_ret]);
                obs[n_ret] = int'(ret_cycle);
            end else begin
                chk(1'b0, {cur_req, " R8 extra retirement"}, n_ret + 1, n_tok);
            end
            n_ret++;
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        n_tok = 0;
        n_ret = 0;
    endtask

    // Offer one token; the model predicts acceptance and retirement (R3, R5, R6).
    task automatic send(input logic [FW-1:0] cnts, input int gap);
        int c [4];
        int a, j, f;
        @(negedge clk);
        repeat (gap) @(negedge clk);
        j = n_tok;
        in_valid = 1'b1;
        in_tag   = TAG_W'(j);
        in_cnt   = cnts;
        for (int k = 0; k < 4; k++) begin
            c[k] = int'(cnts[k*CNT_W +: CNT_W]);
            if (c[k] == 0) c[k] = 1;
        end
        a = cyc;
        if (j > 0 && r_st[j-1][0] > a) a = r_st[j-1][0];
        s_st[j][0] = a + 1;
        for (int k = 0; k < 4; k++) begin
            if (k > 0) begin
                s_st[j][k] = r_st[j][k-1] + 1;
                if (j > 0 && r_st[j-1][k] + 1 > s_st[j][k]) s_st[j][k] = r_st[j-1][k] + 1;
            end
            f = s_st[j][k] + c[k] - 1;
            if (k < 3 && j >= QD && s_st[j-QD][k+1] - 1 > f) f = s_st[j-QD][k+1] - 1;
            r_st[j][k] = f;
        end
        exp_ret[j] = r_st[j][3];
        n_tok = j + 1;
        while (!in_ready) @(negedge clk);
        acc[j] = cyc;
        chk(cyc == a, {cur_req, " R6 acceptance cycle"}, cyc, a);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int w = 0; w < 400 && n_ret < n_tok; w++) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(n_ret == n_tok, {cur_req, " R8 retirement count"}, n_ret, n_tok);
    endtask

    function automatic logic [FW-1:0] pk(input int a1, input int a2, input int a3, input int a4);
        return {CNT_W'(a4), CNT_W'(a3), CNT_W'(a2), CNT_W'(a1)};
    endfunction

    initial begin
        // R9: reset state and counter
        do_reset();
        cur_req = "R9";
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 ready after reset", int'(in_ready), 1);
        chk(ret_valid == 1'b0, "R9 no retirement after reset", int'(ret_valid), 0);
        chk(ret_cycle == '0, "R9 counter first cycle", int'(ret_cycle), 0);
        repeat (5) @(negedge clk);
        chk(ret_cycle == CW'(5), "R9 counter step", int'(ret_cycle), 5);

        // R1: single token, per-stage occupancy sums
        do_reset();
        cur_req = "R1";
        send(pk(3, 5, 2, 7), 0);
        drain();
        chk(obs[0] == 17, "R1 isolated token stamp", obs[0], 17);

        // R10: worked sequence, twice
        do_reset();
        cur_req = "R10";
        for (int p = 0; p < 2; p++) begin
            send(pk(2, 1, 1, 1), 0);
            send(pk(1, 3, 2, 2), 0);
            send(pk(2, 1, 1, 3), 0);
            send(pk(1, 2, 2, 2), 0);
        end
        drain();
        chk(obs[0] == 5,  "R10 pass1 t0", obs[0], 5);
        chk(obs[1] == 10, "R10 pass1 t1", obs[1], 10);
        chk(obs[2] == 13, "R10 pass1 t2", obs[2], 13);
        chk(obs[3] == 15, "R10 pass1 t3", obs[3], 15);
        chk(obs[5] == 18, "R10 pass2 t1", obs[5], 18);
        chk(obs[7] == 23, "R10 last retirement", obs[7], 23);

        // R2: zero counts cost one cycle
        do_reset();
        cur_req = "R2";
        for (int i = 0; i < 3; i++) send(pk(0, 0, 0, 0), 0);
        drain();
        chk(obs[0] == 4, "R2 zero token 0", obs[0], 4);
        chk(obs[2] == 6, "R2 zero token 2", obs[2], 6);

        // R4: stage reallocated while downstream still busy
        do_reset();
        cur_req = "R4";
        send(pk(1, 6, 1, 1), 0);
        send(pk(1, 1, 1, 1), 0);
        send(pk(1, 1, 1, 1), 0);
        drain();
        chk(acc[2] == 2, "R4 early reallocation", acc[2], 2);
        chk(obs[1] == 10, "R4 second token stamp", obs[1], 10);

        // R5: queue fills, stage 1 stalls, input back-pressured
        do_reset();
        cur_req = "R5";
        for (int i = 0; i < 10; i++) send(pk(1, 7, 1, 1), 0);
        drain();
        chk(acc[6] == 8, "R5 stall delays acceptance", acc[6], 8);

        do_reset();
        cur_req = "R5";
        for (int i = 0; i < 12; i++) send(pk(1, 1, 1, 7), 0);
        drain();

        // R3/R7: every count combination as one stream with gaps
        do_reset();
        cur_req = "R3";
        for (int i = 0; i < 4096; i++) send(FW'(i), (i % 7 == 0) ? 1 : 0);
        drain();

        summary();
    end
endmodule